// File: doc/BRIEF.md
# Programmable Local Bus Strobe Timer

This block times one access on an internal local bus. A single 32-bit timing word holds eight 4-bit clock offsets. When the host side reports that its initiator has signalled ready, the block waits two clocks to reach the reference cycle (offset 0). It then counts offsets upward and drives a cycle-active window, a read strobe or a write strobe, and a one-clock completion pulse. The direction is sampled at the moment the access is accepted. The same timing serves I/O-mapped and memory-mapped accesses alike.

Each window is half-open. The cycle window is high from its start offset up to but not including its end offset. A strobe is high from its assert offset up to but not including its deassert offset. Nothing is driven at or past the end offset. The completion pulse marks the end offset, and the block is then free for the next access. A field written with a reserved code (11 to 15) is used as 10. The timing word is copied when an access is accepted, so a rewrite takes effect on the following access.

Top module: `lbus_strobe_timer`

## Requirements
- R1: After reset all outputs are low and the timing word is 0x21212020 (nibbles from bit 0 upward: 0,2,0,2,1,2,1,2).
- R2: An access is accepted on a rising edge where `irdySeen` is high and the block is idle; offset 0 is the clock period that begins two rising edges after the accepting edge.
- R3: `cycleActive` is high during offsets n with start <= n < end. A read (`isWrite`=0) uses start at bits 3:0 and end at bits 7:4. A write (`isWrite`=1) uses start at bits 11:8 and end at bits 15:12.
- R4: In a read access, `rdStrobe` is high during offsets n with assert <= n < deassert, where assert is bits 19:16 and deassert is bits 23:20; `wrStrobe` stays low.
- R5: In a write access, `wrStrobe` is high during offsets n with assert <= n < deassert, where assert is bits 27:24 and deassert is bits 31:28; `rdStrobe` stays low.
- R6: When a deassert offset is less than or equal to its assert offset, that strobe stays low for the whole access.
- R7: `cycleDone` is high for exactly one clock, at offset n = end, and the block is idle after it; an end of 0 gives the pulse at offset 0 alone.
- R8: At and beyond the end offset, `cycleActive`, `rdStrobe` and `wrStrobe` are low, even if a start, assert or deassert value is larger than end.
- R9: `irdySeen` is ignored from the accepting edge through the edge that closes the completion pulse; a level held high starts a new access on the first idle edge.
- R10: A 4-bit field written with 11 to 15 behaves as 10.
- R11: The timing fields and direction used by an access are those present at its accepting edge; a write during the access affects only later accesses.
- R12: The timing word is replaced as a whole on a rising edge with `cfgWe` high; with `cfgWe` low, `cfgWdata` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Timing word write enable |
| cfgWdata | input | 32 | Timing word write data |
| irdySeen | input | 1 | Host initiator ready has been asserted |
| isWrite | input | 1 | Access direction, 1 = write |
| rdStrobe | output | 1 | Local bus read strobe |
| wrStrobe | output | 1 | Local bus write strobe |
| cycleActive | output | 1 | Local bus cycle window |
| cycleDone | output | 1 | One-clock completion pulse at the end offset |

## Verification
Reads and writes are run with the reset timing and with programmed words whose read and write fields all differ. A direction mix-up or a nibble swap therefore shows up as a wrong edge, not as the same waveform. Further cases use an inverted strobe window, an end offset placed before the strobe edges, an end of 0, and reserved codes. These separate the empty-window rule, the truncation at the end offset and the clamp to 10. A ready level held high, a rewrite during an access, and data presented without the write enable are each compared clock by clock with a behavioural model. This shows apart a restart during a busy access, a live-register design and a write port that ignores its enable.

// File: rtl/lbus_timer_pkg.sv
package lbus_timer_pkg;

  // Number of 4-bit offset fields packed in the timing word.
  localparam int NUM_FIELDS = 8;

  // Field slots; the order sets the bit position of each field in the word.
  localparam int F_RD_START = 0;
  localparam int F_RD_END   = 1;
  localparam int F_WR_START = 2;
  localparam int F_WR_END   = 3;
  localparam int F_RD_ON    = 4;
  localparam int F_RD_OFF   = 5;
  localparam int F_WR_ON    = 6;
  localparam int F_WR_OFF   = 7;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic load;      // accept access: snapshot fields and direction
    logic enterRun;  // reference cycle reached: offset counter to 0
    logic step;      // advance offset counter
    logic inRun;     // offset counter is valid
  } timerCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_RUN  = 2'd2
  } timerState_t;

endpackage

// File: rtl/lbus_timer_regs.sv
module lbus_timer_regs
  import lbus_timer_pkg::*;
#(
  parameter int FIELD_W   = 4,
  parameter int MAX_OFF   = 10,
  parameter logic [NUM_FIELDS*FIELD_W-1:0] RESET_VAL = 32'h2121_2020
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  cfgWe,
  input  logic [NUM_FIELDS*FIELD_W-1:0]         cfgWdata,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0]    fields
);

  localparam logic [FIELD_W-1:0] MAX_F = FIELD_W'(MAX_OFF);

  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fieldQ;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    logic [FIELD_W-1:0] wrVal;
    logic [FIELD_W-1:0] clampVal;

    assign wrVal    = cfgWdata[i*FIELD_W +: FIELD_W];
    assign clampVal = (wrVal > MAX_F) ? MAX_F : wrVal;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fieldQ[i] <= RESET_VAL[i*FIELD_W +: FIELD_W];
      end else if (cfgWe) begin
        fieldQ[i] <= clampVal;
      end
    end

    AST_RESERVED_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWe && wrVal > MAX_F) |=> (fieldQ[i] == MAX_F)); // R10

    AST_HOLD_NO_WE: assert property (@(posedge clk) disable iff (!rstN)
      !cfgWe |=> $stable(fieldQ[i])); // R12
  end

  assign fields = fieldQ;

endmodule

// File: rtl/lbus_timer_ctrl.sv
module lbus_timer_ctrl
  import lbus_timer_pkg::*;
#(
  parameter int REF_DELAY = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      irdySeen,
  input  logic      atEnd,
  output timerCtl_t ctl
);

  localparam int PRE_W = (REF_DELAY > 1) ? $clog2(REF_DELAY) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(REF_DELAY - 1);

  timerState_t state;
  timerState_t stateNext;
  logic [PRE_W-1:0] preCnt;

  always_comb begin
    ctl          = '0;
    stateNext    = state;
    ctl.inRun    = (state == ST_RUN);
    unique case (state)
      ST_IDLE: begin
        if (irdySeen) begin
          ctl.load  = 1'b1;
          stateNext = ST_PRE;
        end
      end
      ST_PRE: begin
        if (preCnt == PRE_LAST) begin
          ctl.enterRun = 1'b1;
          stateNext    = ST_RUN;
        end
      end
      ST_RUN: begin
        if (atEnd) stateNext = ST_IDLE;
        else       ctl.step  = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      preCnt <= '0;
    end else begin
      state <= stateNext;
      if (ctl.load)              preCnt <= '0;
      else if (state == ST_PRE)  preCnt <= preCnt + 1'b1;
    end
  end

  AST_ACCEPT_TO_PRE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (state == ST_PRE && preCnt == '0)); // R2

  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |=> (state != ST_PRE)); // R9

  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && atEnd) |=> (state == ST_IDLE)); // R7

endmodule

// File: rtl/lbus_timer_dp.sv
module lbus_timer_dp
  import lbus_timer_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int MAX_OFF = 10
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  timerCtl_t                          ctl,
  input  logic                               isWrite,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fields,
  output logic                               atEnd,
  output logic                               rdStrobe,
  output logic                               wrStrobe,
  output logic                               cycleActive,
  output logic                               cycleDone
);

  localparam logic [FIELD_W-1:0] MAX_F = FIELD_W'(MAX_OFF);

  logic               dirW;
  logic [FIELD_W-1:0] startSnap;
  logic [FIELD_W-1:0] endSnap;
  logic [FIELD_W-1:0] onSnap;
  logic [FIELD_W-1:0] offSnap;
  logic [FIELD_W-1:0] offset;

  logic inWindow;
  logic strobeOn;

  // Snapshot of the fields that belong to the accepted direction.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirW      <= 1'b0;
      startSnap <= '0;
      endSnap   <= '0;
      onSnap    <= '0;
      offSnap   <= '0;
    end else if (ctl.load) begin
      dirW      <= isWrite;
      startSnap <= isWrite ? fields[F_WR_START] : fields[F_RD_START];
      endSnap   <= isWrite ? fields[F_WR_END]   : fields[F_RD_END];
      onSnap    <= isWrite ? fields[F_WR_ON]    : fields[F_RD_ON];
      offSnap   <= isWrite ? fields[F_WR_OFF]   : fields[F_RD_OFF];
    end
  end

  // Offset counter relative to the reference cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             offset <= '0;
    else if (ctl.enterRun) offset <= '0;
    else if (ctl.step)     offset <= offset + 1'b1;
  end

  assign atEnd       = (offset == endSnap);
  assign inWindow    = ctl.inRun && (offset < endSnap);
  assign cycleActive = inWindow && (offset >= startSnap);
  assign strobeOn    = inWindow && (offset >= onSnap) && (offset < offSnap);
  assign rdStrobe    = strobeOn && !dirW;
  assign wrStrobe    = strobeOn && dirW;
  assign cycleDone   = ctl.inRun && atEnd;

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone); // R7

  AST_QUIET_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> !(rdStrobe || wrStrobe || cycleActive)); // R8

  AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ctl.inRun |-> (offset <= MAX_F)); // R10

  AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.inRun |-> ($stable(endSnap) && $stable(dirW))); // R11

endmodule

// File: rtl/lbus_strobe_timer.sv
module lbus_strobe_timer
  import lbus_timer_pkg::*;
#(
  parameter int FIELD_W   = 4,
  parameter int MAX_OFF   = 10,
  parameter int REF_DELAY = 2,
  parameter logic [NUM_FIELDS*FIELD_W-1:0] RESET_VAL = 32'h2121_2020
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgWe,
  input  logic [NUM_FIELDS*FIELD_W-1:0] cfgWdata,
  input  logic                          irdySeen,
  input  logic                          isWrite,
  output logic                          rdStrobe,
  output logic                          wrStrobe,
  output logic                          cycleActive,
  output logic                          cycleDone
);

  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fields;
  timerCtl_t ctl;
  logic atEnd;

  lbus_timer_regs #(
    .FIELD_W   (FIELD_W),
    .MAX_OFF   (MAX_OFF),
    .RESET_VAL (RESET_VAL)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .fields   (fields)
  );

  lbus_timer_ctrl #(
    .REF_DELAY (REF_DELAY)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .irdySeen (irdySeen),
    .atEnd    (atEnd),
    .ctl      (ctl)
  );

  lbus_timer_dp #(
    .FIELD_W (FIELD_W),
    .MAX_OFF (MAX_OFF)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .isWrite     (isWrite),
    .fields      (fields),
    .atEnd       (atEnd),
    .rdStrobe    (rdStrobe),
    .wrStrobe    (wrStrobe),
    .cycleActive (cycleActive),
    .cycleDone   (cycleDone)
  );

endmodule

// File: tb/lbus_strobe_timer_tb.sv
`timescale 1ns/1ps
module lbus_strobe_timer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic        irdySeen = 1'b0;
  logic        isWrite = 1'b0;
  logic        rdStrobe, wrStrobe, cycleActive, cycleDone;

  always #4 clk = ~clk;  // 125 MHz

  lbus_strobe_timer u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .irdySeen(irdySeen), .isWrite(isWrite),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .cycleActive(cycleActive), .cycleDone(cycleDone)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  string curReq  = "R1";
  bit    finished = 0;

  // Behavioural reference model.
  int regF [8];
  bit mBusy;
  int mT;
  bit mDir;
  int mSt, mEn, mOn, mOff;

  function automatic int clampF(int v);
    return (v > 10) ? 10 : v;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) regF[i] = (32'h2121_2020 >> (4*i)) & 15;
      mBusy = 0;
      mT = 0;
    end else begin
      if (mBusy) begin
        if (mT >= 2 && (mT - 2) == mEn) mBusy = 0;
        else mT++;
      end else if (irdySeen) begin
        mBusy = 1;
        mT    = 0;
        mDir  = isWrite;
        mSt   = isWrite ? regF[2] : regF[0];
        mEn   = isWrite ? regF[3] : regF[1];
        mOn   = isWrite ? regF[6] : regF[4];
        mOff  = isWrite ? regF[7] : regF[5];
      end
      if (cfgWe)
        for (int i = 0; i < 8; i++) regF[i] = clampF((cfgWdata >> (4*i)) & 15);
    end
  end

  task automatic chk(string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", curReq, what, act, exp, $time);
    end
  endtask

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit run;
      int n;
      bit eAct, eRd, eWr, eDone, eStr;
      run   = mBusy && (mT >= 2);
      n     = mT - 2;
      eDone = run && (n == mEn);
      eAct  = run && (n < mEn) && (n >= mSt);
      eStr  = run && (n < mEn) && (n >= mOn) && (n < mOff);
      eRd   = eStr && !mDir;
      eWr   = eStr && mDir;
      chk("cycleActive(R3)", cycleActive, eAct);
      chk("rdStrobe(R4)", rdStrobe, eRd);
      chk("wrStrobe(R5)", wrStrobe, eWr);
      chk("cycleDone(R7)", cycleDone, eDone);
    end
  end

  task automatic writeCfg(logic [31:0] w);
    @(negedge clk);
    cfgWe = 1'b1; cfgWdata = w;
    @(negedge clk);
    cfgWe = 1'b0; cfgWdata = '0;
  endtask

  task automatic runAccess(logic dirW);
    @(negedge clk);
    isWrite = dirW; irdySeen = 1'b1;
    @(negedge clk);
    irdySeen = 1'b0; isWrite = ~dirW;  // direction after acceptance must not matter
    repeat (15) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    chk("reset cycleActive", cycleActive, 1'b0);
    chk("reset rdStrobe", rdStrobe, 1'b0);
    chk("reset wrStrobe", wrStrobe, 1'b0);
    chk("reset cycleDone", cycleDone, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R2: reset timing word, both directions.
    curReq = "R1"; runAccess(1'b0); runAccess(1'b1);

    // R3 R4 R5: distinct read and write fields.
    curReq = "R3";
    writeCfg({4'd6, 4'd2, 4'd8, 4'd4, 4'd9, 4'd1, 4'd5, 4'd3});
    runAccess(1'b0);
    curReq = "R5"; runAccess(1'b1);

    // R2: one-offset window starting at the reference cycle.
    curReq = "R2";
    writeCfg({4'd1, 4'd0, 4'd1, 4'd0, 4'd1, 4'd0, 4'd1, 4'd0});
    runAccess(1'b0); runAccess(1'b1);

    // R6: empty and inverted strobe windows.
    curReq = "R6";
    writeCfg({4'd2, 4'd6, 4'd5, 4'd5, 4'd8, 4'd0, 4'd8, 4'd0});
    runAccess(1'b0); runAccess(1'b1);

    // R8: end before the strobe edges truncates everything.
    curReq = "R8";
    writeCfg({4'd9, 4'd1, 4'd8, 4'd2, 4'd3, 4'd1, 4'd3, 4'd4});
    runAccess(1'b0); runAccess(1'b1);

    // R7: end of 0 gives a lone pulse at offset 0.
    curReq = "R7";
    writeCfg({4'd5, 4'd0, 4'd5, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0});
    runAccess(1'b0); runAccess(1'b1);

    // R10: reserved codes act as 10.
    curReq = "R10";
    writeCfg({4'hF, 4'hC, 4'hD, 4'h3, 4'hB, 4'h9, 4'hE, 4'h2});
    runAccess(1'b0); runAccess(1'b1);

    // R9: ready held high across several accesses.
    curReq = "R9";
    writeCfg({4'd4, 4'd1, 4'd3, 4'd0, 4'd5, 4'd2, 4'd3, 4'd1});
    @(negedge clk);
    isWrite = 1'b0; irdySeen = 1'b1;
    repeat (40) @(negedge clk);
    isWrite = 1'b1;
    repeat (30) @(negedge clk);
    irdySeen = 1'b0;
    repeat (15) @(negedge clk);

    // R11: rewrite during an access takes effect only on the next one.
    curReq = "R11";
    @(negedge clk);
    isWrite = 1'b0; irdySeen = 1'b1;
    @(negedge clk);
    irdySeen = 1'b0; cfgWe = 1'b1;
    cfgWdata = {4'd2, 4'd1, 4'd2, 4'd1, 4'd7, 4'd0, 4'd1, 4'd0};
    @(negedge clk);
    cfgWe = 1'b0; cfgWdata = '0;
    repeat (15) @(negedge clk);
    runAccess(1'b0);

    // R12: data without the enable has no effect.
    curReq = "R12";
    @(negedge clk);
    cfgWdata = 32'hA0A0_A0A0;
    repeat (3) @(negedge clk);
    cfgWdata = '0;
    runAccess(1'b0); runAccess(1'b1);

    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired in %s", curReq);
      summary();
    end
  end

endmodule